// File: doc/BRIEF.md
# CAN CRC-15 Generator and Checker

This block computes the 15-bit CAN frame checksum serially, one bit at a time, over the bitstream after the stuff bits have been removed. A neighbouring frame sequencer gives it four things: a start-of-frame pulse, a strobe for each destuffed bit together with that bit's value, a flag that marks the bits of the CRC field, and a mode select that picks transmit or receive.

In transmit mode, the running remainder after the last data bit is the checksum. During the CRC field, the block presents the checksum most significant bit first on `tx_bit`, and each strobe shifts the next bit into place. In receive mode, the 15 received CRC bits pass through the same divider. A remainder of zero after the last of those bits means the frame is intact, and the block reports the pass/fail result to the error logic. Bit destuffing, frame parsing and the delimiter check are handled elsewhere.

Top module: `can_crc15_unit`

## Requirements
- R1: After reset, `crc_rem` is zero and `chk_valid` and `chk_ok` are low.
- R2: A cycle with `sof` high clears the remainder and the CRC-bit count. If `bit_vld` is also high in that cycle, its bit is the first bit included, so the new remainder is one step from zero.
- R3: Each strobed bit outside the CRC field applies one step. The feedback is `bit_in` XOR `crc_rem[14]`. The register shifts left by one with zero fill, and it is then XORed with 15'h4599 when the feedback is 1. This is the generator x^15+x^14+x^10+x^8+x^7+x^4+x^3+1.
- R4: In a cycle with `bit_vld` low and `sof` low, the remainder and the result outputs keep their values. This is how stuff bits are left out.
- R5: In transmit mode (`rx_mode`=0), while `crc_phase` is high, `tx_bit` equals `crc_rem[14]`. Each strobe shifts the remainder left with zero fill and ignores `bit_in`, so the 15 checksum bits leave MSB first and the remainder is zero afterwards.
- R6: In receive mode (`rx_mode`=1), CRC-field bits apply the R3 step. In the cycle after the 15th such bit, `chk_valid` is 1 and `chk_ok` is 1 exactly when the remainder is zero.
- R7: Once 15 CRC bits have been taken, further CRC-field strobes change nothing. `chk_valid` and `chk_ok` hold until the next `sof`.
- R8: In transmit mode, `chk_valid` and `chk_ok` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof | input | 1 | Start of frame: clear remainder and count |
| bit_vld | input | 1 | Destuffed bit strobe |
| bit_in | input | 1 | Destuffed bit value |
| crc_phase | input | 1 | Marks bits of the CRC field |
| rx_mode | input | 1 | 1 = receive check, 0 = transmit generate |
| crc_rem | output | 15 | Running remainder |
| tx_bit | output | 1 | Next checksum bit to send (MSB of remainder) |
| chk_valid | output | 1 | Receive check result available |
| chk_ok | output | 1 | Receive checksum matched |

## Verification
Every result is registered. A strobe sampled at one edge shows in `crc_rem` and `tx_bit` right after that edge, and the receive verdict appears right after the edge that takes the 15th CRC bit. The bench drives its inputs one time unit after a rising edge and compares outputs at the same offset after the next edge, so each comparison sees exactly one update. It also confirms that `chk_valid` is still low after the 14th CRC bit.

// File: rtl/can_crc15_unit.sv
module can_crc15_unit #(
  parameter int W = 15,
  parameter logic [W-1:0] POLY = 15'h4599
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sof,
  input  logic         bit_vld,
  input  logic         bit_in,
  input  logic         crc_phase,
  input  logic         rx_mode,
  output logic [W-1:0] crc_rem,
  output logic         tx_bit,
  output logic         chk_valid,
  output logic         chk_ok
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  rem_q;
  logic [CW-1:0] cnt_q;
  logic          vld_q, ok_q;

  wire [W-1:0]  base     = sof ? '0 : rem_q;
  wire [CW-1:0] cnt_base = sof ? '0 : cnt_q;
  wire          take     = bit_vld && !(crc_phase && cnt_base == FULL);
  wire          fb       = (rx_mode || !crc_phase) ? (bit_in ^ base[W-1]) : 1'b0;
  wire [W-1:0]  stepped  = {base[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  wire          last_rx  = take && crc_phase && rx_mode && cnt_base == LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      cnt_q <= '0;
      vld_q <= 1'b0;
      ok_q  <= 1'b0;
    end else begin
      if (sof || take) rem_q <= take ? stepped : '0;
      if (sof || (take && crc_phase))
        cnt_q <= (take && crc_phase) ? cnt_base + 1'b1 : '0;
      if (last_rx) begin
        vld_q <= 1'b1;
        ok_q  <= (stepped == '0);
      end else if (sof) begin
        vld_q <= 1'b0;
        ok_q  <= 1'b0;
      end
    end
  end

  assign crc_rem   = rem_q;
  assign tx_bit    = rem_q[W-1];
  assign chk_valid = vld_q;
  assign chk_ok    = ok_q;

  // R4
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof && !bit_vld) |=> ($stable(crc_rem) && $stable(chk_valid) && $stable(chk_ok)));

  // R2
  sof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !bit_vld) |=> (crc_rem == '0 && !chk_valid));

  // R5
  tx_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof && bit_vld && crc_phase && !rx_mode && cnt_q != FULL)
      |=> crc_rem == {$past(crc_rem[W-2:0]), 1'b0});

  // R7
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !sof) |=> (chk_valid && $stable(chk_ok) && $stable(crc_rem)));

  // R6
  verdict_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chk_valid) |-> $past(bit_vld && crc_phase && rx_mode));

  // R8
  ok_implies_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ok |-> chk_valid);
endmodule

// File: tb/test_can_crc15_unit.sv
module test_can_crc15_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sof = 0, bit_vld = 0, bit_in = 0, crc_phase = 0, rx_mode = 0;
  logic [14:0] crc_rem;
  logic tx_bit, chk_valid, chk_ok;
  int total = 0, bad = 0;
  logic [14:0] mdl;

  always #4 clk = ~clk;

  can_crc15_unit i_can_crc15_unit (
    .clk(clk), .rst_n(rst_n), .sof(sof), .bit_vld(bit_vld), .bit_in(bit_in),
    .crc_phase(crc_phase), .rx_mode(rx_mode), .crc_rem(crc_rem), .tx_bit(tx_bit),
    .chk_valid(chk_valid), .chk_ok(chk_ok));

  function automatic logic [14:0] crc_step(logic [14:0] r, logic b);
    logic f = b ^ r[14];
    return {r[13:0], 1'b0} ^ (f ? 15'h4599 : 15'h0);
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic s, logic v, logic b, logic ph);
    sof = s; bit_vld = v; bit_in = b; crc_phase = ph;
    @(posedge clk); #1;
    sof = 0; bit_vld = 0;
  endtask

  task automatic send_data(int n, logic rx);
    rx_mode = rx;
    mdl = 15'h0;
    for (int i = 0; i < n; i++) begin
      logic b = 1'($urandom);
      if ($urandom % 4 == 0) begin
        drive(0, 0, ~b, 0);
        chk("R4", crc_rem, mdl);
      end
      mdl = crc_step(mdl, b);
      drive(i == 0, 1, b, 0);
      chk(i == 0 ? "R2" : "R3", crc_rem, mdl);
    end
  endtask

  initial begin
    void'($urandom(32'd1701));
    #20;
    chk("R1", {crc_rem, chk_valid, chk_ok}, 0);
    @(posedge clk); #1; rst_n = 1;

    drive(1, 1, 1, 0);
    chk("R2", crc_rem, 15'h4599);
    drive(1, 0, 0, 0);
    chk("R2", crc_rem, 0);

    for (int f = 0; f < 6; f++) begin
      logic [14:0] crc;
      send_data(20 + $urandom % 60, 0);
      crc = mdl;
      for (int k = 14; k >= 0; k--) begin
        chk("R5", tx_bit, crc[k]);
        drive(0, 1, 1'($urandom), 1);
      end
      chk("R5", crc_rem, 0);
      chk("R8", {chk_valid, chk_ok}, 0);
    end

    for (int f = 0; f < 12; f++) begin
      logic [14:0] crc;
      logic corrupt = (f % 3 == 2);
      int flip = $urandom % 15;
      send_data(20 + $urandom % 60, 1);
      crc = mdl;
      if (corrupt) crc[flip] = ~crc[flip];
      for (int k = 14; k >= 0; k--) begin
        if (k == 0) chk("R6", chk_valid, 0);
        drive(0, 1, crc[k], 1);
      end
      chk("R6", chk_valid, 1);
      chk("R6", chk_ok, !corrupt);
      begin
        logic [14:0] keep = crc_rem;
        drive(0, 1, 1'($urandom), 1);
        chk("R7", {crc_rem, chk_valid, chk_ok}, {keep, 1'b1, !corrupt});
        drive(0, 0, 0, 0);
        chk("R7", {chk_valid, chk_ok}, {1'b1, !corrupt});
      end
      drive(1, 0, 0, 0);
      chk("R2", {crc_rem, chk_valid, chk_ok}, 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule